// File: doc/BRIEF.md
# Level-Shifted Multicarrier PWM Modulator

This block produces switch commands for up to three legs of a diode-clamped multilevel inverter that has either three or five output levels. A shared up/down counter makes a family of triangular carriers that are stacked vertically so that together they cover the whole reference range. A phase accumulator and a quarter-wave table make a sampled sinusoid for phase A. Phases B and C use the same waveform, delayed by one third and two thirds of a turn. In each leg, the reference is compared with every active carrier. The number of carriers it lies strictly above is the output level. That level is then decoded into a contiguous window of conducting switches.

The relative phase of the carriers is selectable. All carriers can rise together. The carriers above zero can run opposite to those below zero. Or each carrier can run opposite to its neighbour. The level count, the carrier arrangement and the modulation index are sampled only when the carrier counter returns to zero, so a change never splits a carrier period. The frequency word acts on every cycle. For example, a 10 kHz carrier with a 50 Hz reference needs a frequency word of about 2^ACC_W / (200 · 2·CAR_HALF).

Top module: `mlpwm_mod`

## Requirements
- R1: While `rst_ni` is low, every bit of all three gate vectors is 0.
- R2: The carrier counter starts at 0 after reset, then steps by one each cycle from 0 up to CAR_HALF and back down to 0. One carrier period is 2·CAR_HALF cycles. Let C = CAR_HALF. In five-level operation, carrier k (k = 0..3) is −2C + k·C + t_k. In three-level operation, carrier k (k = 0..1) is −2C + 2k·C + 2·t_k. Here t_k is either the counter value or C minus the counter value.
- R3: With `disp_mode_i` = 0 (or the spare code 3), every carrier uses t_k = counter, so all carriers rise and fall together.
- R4: With `disp_mode_i` = 1, the carriers in the upper half use t_k = counter and those in the lower half use t_k = C − counter. The upper half is k ≥ 2 for five-level operation and k = 1 for three-level operation.
- R5: With `disp_mode_i` = 2, the top carrier uses t_k = counter and each carrier below it uses the opposite phase from its neighbour above. For a three-level leg the resulting outputs are identical to those of mode 1.
- R6: The level equals the number of active carriers that the reference is strictly greater than. A reference equal to a carrier does not count as exceeding it.
- R7: In five-level operation, the gate vector bits 7..4 are the upper switches (outermost first) and bits 3..0 are the lower switches (outermost first). Levels 4, 3, 2, 1 and 0 give 8'hF0, 8'h78, 8'h3C, 8'h1E and 8'h0F.
- R8: In three-level operation, bits 7..4 are 0 and bits 3..0 are the two upper switches followed by the two lower switches. Levels 2, 1 and 0 give 8'h0C, 8'h06 and 8'h03.
- R9: The phase accumulator is cleared by reset and adds `freq_word_i` on every cycle. The top two phase bits select the quadrant and the next SIN_QB bits give f. The table index is f in quadrants 0 and 2, and Q − f in quadrants 1 and 3, where Q = 2^SIN_QB. The table value is T = (2C·i·(2Q − i)) / (Q·Q). The magnitude is (T · index) >> MIDX_W, and it is negated in quadrants 2 and 3.
- R10: Phase B uses the phase A accumulator minus ⌊2^ACC_W/3⌋ and phase C uses it minus twice that value (modulo 2^ACC_W). All three phases share one carrier set.
- R11: The level count, carrier mode and modulation index are copied from the inputs on the clock edge at which the counter goes from 1 to 0. Until that edge, changes to those inputs have no effect on the gates.
- R12: The gates are registered. A gate vector reflects the counter, accumulator and sampled settings that were present one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| five_lvl_i | input | 1 | 1 = five-level leg, 0 = three-level leg |
| disp_mode_i | input | 2 | Carrier arrangement: 0 all in phase, 1 halves opposed, 2 neighbours opposed |
| mod_idx_i | input | MIDX_W | Modulation index; the reference is scaled by mod_idx_i / 2^MIDX_W |
| freq_word_i | input | ACC_W | Phase increment per cycle |
| gate_a_o | output | 8 | Switch commands, phase A |
| gate_b_o | output | 8 | Switch commands, phase B |
| gate_c_o | output | 8 | Switch commands, phase C |

## Verification
A reference held exactly at zero lands on a carrier peak once per period. A design that counted equality as exceeding would emit the wrong pattern there, and a design with a wrong period would show that pattern at the wrong spacing. A level-count change made in the middle of a period must not alter the gates until the counter wraps, so a design that applied settings immediately would change the switch count too early. Long runs across all three carrier arrangements, both level counts and several frequency words are compared cycle by cycle against an independent model of the stated arithmetic. These runs expose inverted carrier phases, three-level arrangements that disagree between the opposed modes, wrong quadrant folding or phase offsets, and a missing register stage.

// File: rtl/mlpwm_pkg.sv
package mlpwm_pkg;
  typedef enum logic [1:0] {
    DISP_SAME = 2'd0,
    DISP_HALF = 2'd1,
    DISP_ALT  = 2'd2,
    DISP_SPARE = 2'd3
  } disp_e;

  localparam int NCAR_MAX = 4;
  localparam int GATE_W   = 8;
endpackage

// File: rtl/mlpwm_carrier.sv
module mlpwm_carrier
  import mlpwm_pkg::*;
#(
  parameter int CAR_HALF = 32,
  parameter int RW       = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 five_i,
  input  logic [1:0]           mode_i,
  output logic signed [RW-1:0] car_o [NCAR_MAX],
  output logic                 wrap_o
);
  localparam int CW = $clog2(CAR_HALF + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          up_q, up_d;

  always_comb begin
    cnt_d = cnt_q;
    up_d  = up_q;
    if (up_q) begin
      if (cnt_q == CW'(CAR_HALF)) begin
        cnt_d = cnt_q - 1'b1;
        up_d  = 1'b0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) up_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign wrap_o = !up_q && (cnt_q == CW'(1));

  for (genvar k = 0; k < NCAR_MAX; k++) begin : g_car
    logic                 inv;
    logic [CW-1:0]        tri_v;
    logic signed [RW-1:0] car_w;
    int                   v;

    always_comb begin
      case (disp_e'(mode_i))
        DISP_HALF: inv = five_i ? (k < 2) : (k < 1);
        DISP_ALT:  inv = ((k % 2) == 0);
        default:   inv = 1'b0;
      endcase
      tri_v = inv ? (CW'(CAR_HALF) - cnt_q) : cnt_q;
      if (five_i) v = k * CAR_HALF + int'(tri_v) - 2 * CAR_HALF;
      else        v = 2 * k * CAR_HALF + 2 * int'(tri_v) - 2 * CAR_HALF;
      car_w = RW'(v);
    end

    assign car_o[k] = car_w;
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(CAR_HALF));

  // R2
  cnt_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && cnt_q != CW'(CAR_HALF)) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/mlpwm_ref.sv
module mlpwm_ref #(
  parameter int CAR_HALF = 32,
  parameter int ACC_W    = 24,
  parameter int SIN_QB   = 4,
  parameter int MIDX_W   = 8,
  parameter int RW       = 8
) (
  input  logic [ACC_W-1:0]     phase_i,
  input  logic [MIDX_W-1:0]    midx_i,
  output logic signed [RW-1:0] ref_o
);
  localparam int Q  = 1 << SIN_QB;
  localparam int TW = $clog2(2 * CAR_HALF + 1);
  localparam int PW = TW + MIDX_W;

  function automatic int quarter_val(int i);
    return (2 * CAR_HALF * i * (2 * Q - i)) / (Q * Q);
  endfunction

  logic [TW-1:0] tab [Q+1];
  for (genvar i = 0; i <= Q; i++) begin : g_tab
    assign tab[i] = TW'(quarter_val(i));
  end

  logic [1:0]           quad;
  logic [SIN_QB-1:0]    frac;
  logic [SIN_QB:0]      idx;
  logic [PW-1:0]        prod;
  logic [TW-1:0]        mag;
  logic signed [RW-1:0] mag_s;

  assign quad  = phase_i[ACC_W-1 -: 2];
  assign frac  = phase_i[ACC_W-3 -: SIN_QB];
  assign idx   = quad[0] ? ((SIN_QB+1)'(Q) - {1'b0, frac}) : {1'b0, frac};
  assign prod  = PW'(tab[idx]) * PW'(midx_i);
  assign mag   = TW'(prod >> MIDX_W);
  assign mag_s = RW'(mag);
  assign ref_o = quad[1] ? -mag_s : mag_s;
endmodule

// File: rtl/mlpwm_leg.sv
module mlpwm_leg
  import mlpwm_pkg::*;
#(
  parameter int RW = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 five_i,
  input  logic signed [RW-1:0] ref_i,
  input  logic signed [RW-1:0] car_i [NCAR_MAX],
  output logic [GATE_W-1:0]    gate_o
);
  logic [2:0]        lvl;
  logic [GATE_W-1:0] gate_d, gate_q;

  always_comb begin
    lvl = '0;
    for (int k = 0; k < NCAR_MAX; k++) begin
      if ((five_i || k < 2) && (ref_i > car_i[k])) lvl = lvl + 3'd1;
    end
    if (five_i) gate_d = 8'h0F << lvl;
    else        gate_d = {4'h0, 4'h3 << lvl[1:0]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) gate_q <= '0;
    else         gate_q <= gate_d;
  end

  assign gate_o = gate_q;

  // R7
  gate_weight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q != '0) |-> ($countones(gate_q) == ($past(five_i) ? 4 : 2)));

  // R8
  three_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(five_i) && gate_q != '0) |->
      (gate_q[7:4] == 4'h0 && gate_q[3] != gate_q[1] && gate_q[2] != gate_q[0]));
endmodule

// File: rtl/mlpwm_mod.sv
module mlpwm_mod
  import mlpwm_pkg::*;
#(
  parameter int CAR_HALF = 32,
  parameter int ACC_W    = 24,
  parameter int SIN_QB   = 4,
  parameter int MIDX_W   = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              five_lvl_i,
  input  logic [1:0]        disp_mode_i,
  input  logic [MIDX_W-1:0] mod_idx_i,
  input  logic [ACC_W-1:0]  freq_word_i,
  output logic [7:0]        gate_a_o,
  output logic [7:0]        gate_b_o,
  output logic [7:0]        gate_c_o
);
  localparam int RW = $clog2(2 * CAR_HALF + 1) + 1;
  localparam logic [ACC_W-1:0] THIRD = ACC_W'((64'd1 << ACC_W) / 3);

  logic [ACC_W-1:0]  acc_q, acc_d;
  logic              five_q, five_d;
  logic [1:0]        mode_q, mode_d;
  logic [MIDX_W-1:0] midx_q, midx_d;
  logic              wrap;

  always_comb begin
    acc_d  = acc_q + freq_word_i;
    five_d = five_q;
    mode_d = mode_q;
    midx_d = midx_q;
    if (wrap) begin
      five_d = five_lvl_i;
      mode_d = disp_mode_i;
      midx_d = mod_idx_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      five_q <= 1'b0;
      mode_q <= DISP_SAME;
      midx_q <= '0;
    end else begin
      acc_q  <= acc_d;
      five_q <= five_d;
      mode_q <= mode_d;
      midx_q <= midx_d;
    end
  end

  logic signed [RW-1:0] car [NCAR_MAX];

  mlpwm_carrier #(.CAR_HALF(CAR_HALF), .RW(RW)) u_car (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .five_i (five_q),
    .mode_i (mode_q),
    .car_o  (car),
    .wrap_o (wrap)
  );

  logic [2:0][GATE_W-1:0] gates;

  for (genvar p = 0; p < 3; p++) begin : g_phase
    logic [ACC_W-1:0]     ph;
    logic signed [RW-1:0] refv;

    assign ph = acc_q - ACC_W'(p * THIRD);

    mlpwm_ref #(
      .CAR_HALF(CAR_HALF), .ACC_W(ACC_W), .SIN_QB(SIN_QB),
      .MIDX_W(MIDX_W), .RW(RW)
    ) u_ref (
      .phase_i (ph),
      .midx_i  (midx_q),
      .ref_o   (refv)
    );

    mlpwm_leg #(.RW(RW)) u_leg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .five_i (five_q),
      .ref_i  (refv),
      .car_i  (car),
      .gate_o (gates[p])
    );
  end

  assign gate_a_o = gates[0];
  assign gate_b_o = gates[1];
  assign gate_c_o = gates[2];

  // R11
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> $stable({five_q, mode_q, midx_q}));
endmodule

// File: tb/sim_mlpwm_mod.sv
`timescale 1ns/1ps
module sim_mlpwm_mod;
  localparam int C   = 32;
  localparam int AW  = 24;
  localparam int QB  = 4;
  localparam int MW  = 8;
  localparam logic [AW-1:0] OFS = 24'd5592405;

  typedef struct packed {
    logic        five;
    logic [1:0]  mode;
    logic [7:0]  midx;
    logic [23:0] fw;
    logic [15:0] ncyc;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b1, 2'd0, 8'd200, 24'd32768, 16'd600},
    '{1'b1, 2'd1, 8'd255, 24'd40001, 16'd600},
    '{1'b1, 2'd2, 8'd128, 24'd32768, 16'd600},
    '{1'b0, 2'd0, 8'd255, 24'd32768, 16'd600},
    '{1'b0, 2'd1, 8'd180, 24'd50000, 16'd400},
    '{1'b0, 2'd2, 8'd180, 24'd50000, 16'd400},
    '{1'b1, 2'd3, 8'd240, 24'd70001, 16'd400},
    '{1'b1, 2'd2, 8'd0,   24'd1311,  16'd200}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        five = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [7:0]  midx = 8'd0;
  logic [23:0] fw = 24'd0;
  logic [7:0]  ga, gb, gc;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  mlpwm_mod #(.CAR_HALF(C), .ACC_W(AW), .SIN_QB(QB), .MIDX_W(MW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .five_lvl_i(five), .disp_mode_i(mode),
    .mod_idx_i(midx), .freq_word_i(fw),
    .gate_a_o(ga), .gate_b_o(gb), .gate_c_o(gc)
  );

  // Independent model written from the requirements
  function automatic int sine_ref(logic [AW-1:0] ph, int m);
    int q, f, i, t, mag;
    q = int'(ph[AW-1:AW-2]);
    f = int'(ph[AW-3:AW-2-QB]);
    i = (q == 1 || q == 3) ? (16 - f) : f;
    t = (2 * C * i * (32 - i)) / 256;
    mag = (t * m) >>> MW;
    return (q >= 2) ? -mag : mag;
  endfunction

  function automatic int carrier(int k, int cnt, bit fv, int md);
    bit opp;
    int t;
    int top;
    top = fv ? 3 : 1;
    if (md == 1)      opp = fv ? (k <= 1) : (k == 0);
    else if (md == 2) opp = ((top - k) % 2) == 1;
    else              opp = 1'b0;
    t = opp ? (C - cnt) : cnt;
    return fv ? (-2 * C + k * C + t) : (-2 * C + 2 * k * C + 2 * t);
  endfunction

  function automatic logic [7:0] expect_gate(int r, int cnt, bit fv, int md);
    int n;
    n = 0;
    for (int k = 0; k < (fv ? 4 : 2); k++) if (r > carrier(k, cnt, fv, md)) n++;
    if (fv) begin
      case (n)
        4: return 8'hF0;
        3: return 8'h78;
        2: return 8'h3C;
        1: return 8'h1E;
        default: return 8'h0F;
      endcase
    end
    case (n)
      2: return 8'h0C;
      1: return 8'h06;
      default: return 8'h03;
    endcase
  endfunction

  int          m_cnt;
  bit          m_up;
  logic [23:0] m_acc;
  bit          m_five;
  int          m_mode;
  int          m_midx;
  logic [7:0]  m_exp [3];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= 0; m_up <= 1'b1; m_acc <= '0;
      m_five <= 1'b0; m_mode <= 0; m_midx <= 0;
      for (int p = 0; p < 3; p++) m_exp[p] <= 8'h00;
    end else begin
      for (int p = 0; p < 3; p++)
        m_exp[p] <= expect_gate(sine_ref(m_acc - 24'(p) * OFS, m_midx), m_cnt, m_five, m_mode);
      if (m_up) begin
        if (m_cnt == C) begin m_cnt <= C - 1; m_up <= 1'b0; end
        else m_cnt <= m_cnt + 1;
      end else begin
        m_cnt <= m_cnt - 1;
        if (m_cnt == 1) begin
          m_up <= 1'b1;
          m_five <= five; m_mode <= int'(mode); m_midx <= int'(midx);
        end
      end
      m_acc <= m_acc + fw;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [7:0] got, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: gates low during reset
    chk(ga == 8'h00 && gb == 8'h00 && gc == 8'h00, "R1 reset", ga | gb | gc, 8'h00);
    rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 200000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    string tag;
    repeat (2) @(negedge clk);
    do_reset();

    // Table walk: every cycle, every phase compared with the model (R2 R9 R10 R12)
    for (int v = 0; v < 8; v++) begin
      five = VECS[v].five; mode = VECS[v].mode;
      midx = VECS[v].midx; fw = VECS[v].fw;
      case (VECS[v].mode)
        2'd1: tag = "R4";
        2'd2: tag = "R5";
        default: tag = "R3";
      endcase
      tag = {tag, VECS[v].five ? " R7" : " R8", " R2 R6 R9 R10 R12"};
      for (int n = 0; n < int'(VECS[v].ncyc); n++) begin
        @(negedge clk);
        chk(ga == m_exp[0], {tag, " phase A"}, ga, m_exp[0]);
        chk(gb == m_exp[1], {tag, " phase B"}, gb, m_exp[1]);
        chk(gc == m_exp[2], {tag, " phase C"}, gc, m_exp[2]);
      end
    end

    // R6 and R2: zero reference, five-level, all carriers in phase
    five = 1'b1; mode = 2'd0; midx = 8'd0; fw = 24'd0;
    do_reset();
    repeat (2 * C + 4) @(negedge clk);
    begin
      int peaks;
      int others_bad;
      peaks = 0; others_bad = 0;
      for (int n = 0; n < 2 * C; n++) begin
        @(negedge clk);
        if (ga == 8'h1E) peaks++;
        else if (ga != 8'h3C) others_bad++;
        chk(gb == ga && gc == ga, "R6 equal refs", gb, ga);
      end
      chk(peaks == 1, "R2 one peak per period", 8'(peaks), 8'd1);
      chk(others_bad == 0, "R6 equality not exceeding", 8'(others_bad), 8'd0);
    end

    // R11: switch to three-level in mid-period
    begin
      int guard;
      guard = 0;
      while (ga != 8'h1E && guard < 4 * C) begin
        @(negedge clk);
        guard++;
      end
      chk(ga == 8'h1E, "R11 find peak", ga, 8'h1E);
      five = 1'b0;
      @(negedge clk);
      chk(ga == 8'h3C, "R11 held until wrap", ga, 8'h3C);
      repeat (C + 1) @(negedge clk);
      chk(ga == 8'h06, "R11 applied after wrap R8", ga, 8'h06);
    end

    // R5: three-level with neighbours opposed matches halves opposed
    begin
      logic [7:0] pod_a [2 * C];
      five = 1'b0; mode = 2'd1; midx = 8'd200; fw = 24'd60000;
      do_reset();
      repeat (2 * C + 2) @(negedge clk);
      for (int n = 0; n < 2 * C; n++) begin @(negedge clk); pod_a[n] = ga; end
      mode = 2'd2;
      do_reset();
      repeat (2 * C + 2) @(negedge clk);
      for (int n = 0; n < 2 * C; n++) begin
        @(negedge clk);
        chk(ga == pod_a[n], "R5 three-level modes agree", ga, pod_a[n]);
      end
    end

    // R1 again: reset asserted mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ga == 8'h00 && gb == 8'h00 && gc == 8'h00, "R1 mid-run reset", ga | gb | gc, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    summary();
  end
endmodule